// File: doc/BRIEF.md
# Interrupt Presenter Dispatch Scanner

This block sits after the interrupt routing stage. For each notification it is handed, it finds the hardware thread that is running the target context right now. A request carries a format bit, the target's block and index, an ignore flag, a priority and a logical server number. The block reads a one-bit descriptor-valid flag for the target from a small local table, which is written through a simple write port. It then walks the contexts of all hardware threads, one thread per clock, and sends each context through a single ring matcher.

The result is one of four outcomes. The first is a single matching thread, reported with its ring. The second is a duplicate match, raised when two or more threads claim the target. The third is "not dispatched", a normal outcome that a later stage can turn into escalation or backlog. The fourth is an invalid request. The scan always runs to the last thread, even after a hit, so that duplicates are never missed. Requests enter through a valid/ready handshake. Results leave on a one-cycle done strobe.

Top module: `disp_presenter_scan`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is high only while the block is idle. It is low from the cycle after the accepting edge through the done cycle, and it is high again in the cycle right after the done cycle.
- R2: The target id is `{req_blk, req_idx}`. The request is rejected with status 3 (invalid) and no thread scan if either condition holds: the id is not below `TBL_DEPTH`, or its table bit is clear. Count the accepting edge as edge 0. A rejected request shows `res_done` in the cycle after edge 1. A scanned request shows it in the cycle after edge `NUM_THR+1`.
- R3: A format-0 request with the ignore flag set is a logical-server request and is rejected with status 3. For format 1 the ignore flag has no effect.
- R4: `tbl_we` writes `tbl_vld` into entry `tbl_addr` at a rising edge.
- R5: Format 0 uses three rings, each encoded on `res_ring`: physical (3), pool (2) and OS (1). A ring matches when its valid bit is set and its id equals the target id. When several rings of one thread match, physical wins over pool, and pool wins over OS.
- R6: Format 1 uses only the user ring (encoded 0). It matches when three things hold: the OS ring is valid with an id equal to the target, the user valid bit is set, and the user logical server equals `req_ls`.
- R7: A thread whose `thr_en` bit is clear never matches.
- R8: When exactly one enabled thread matches, the status is 0 (found). `res_thread` carries that thread's index and `res_ring` its ring.
- R9: When two or more enabled threads match, the status is 1 (duplicate). Every thread is still scanned, so latency does not change.
- R10: When no enabled thread matches a valid target, the status is 2 (not dispatched).
- R11: `res_done` is high for exactly one cycle. In that cycle `res_status`, `res_thread`, `res_ring` and `res_prio` are valid. `res_thread` and `res_ring` are zero unless the status is found. `res_prio` echoes the accepted priority.
- R12: After reset, `req_ready` is high, `res_done` is low and every table entry is clear.
- R13: Request inputs are captured at acceptance. Changing them while the block is busy has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_fmt | input | 1 | 0: single target, 1: user-level target |
| req_blk | input | BLK_W | Target block |
| req_idx | input | IDX_W | Target index within the block |
| req_ign | input | 1 | Ignore flag (logical-server request when format is 0) |
| req_prio | input | PRIO_W | Priority, echoed on the result |
| req_ls | input | LS_W | Logical server number (format 1) |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | TBL_AW | Table entry written |
| tbl_vld | input | 1 | Descriptor-valid value written |
| thr_en | input | NUM_THR | Per-thread enable |
| ctx_phys_vld | input | NUM_THR | Physical ring valid, per thread |
| ctx_phys_id | input | NUM_THR*ID_W | Physical ring id, per thread |
| ctx_pool_vld | input | NUM_THR | Pool ring valid, per thread |
| ctx_pool_id | input | NUM_THR*ID_W | Pool ring id, per thread |
| ctx_os_vld | input | NUM_THR | OS ring valid, per thread |
| ctx_os_id | input | NUM_THR*ID_W | OS ring id, per thread |
| ctx_usr_vld | input | NUM_THR | User ring valid, per thread |
| ctx_usr_ls | input | NUM_THR*LS_W | User ring logical server, per thread |
| res_done | output | 1 | One-cycle result strobe |
| res_status | output | 2 | 0 found, 1 duplicate, 2 not dispatched, 3 invalid |
| res_thread | output | THR_W | Matching thread index |
| res_ring | output | 2 | Matching ring |
| res_prio | output | PRIO_W | Priority of the request |

## Verification
The bench uses the default build: four threads, a six-bit target id and a 16-entry table. These values let it sweep every target id, which covers ids in range, ids out of range, and set and cleared table entries. For a fixed valid target it also crosses all 16 match patterns with all 16 thread-enable masks, in both formats. That cross reaches every first-match position, every duplicate count and every ring-priority combination. Request inputs are scrambled after each acceptance, and every result's latency is counted.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef enum logic [1:0] {
    ST_FOUND   = 2'd0,
    ST_DUP     = 2'd1,
    ST_NODISP  = 2'd2,
    ST_INVALID = 2'd3
  } res_status_e;

  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_PHYS = 2'd3
  } ring_e;

  typedef enum logic [1:0] {
    FSM_IDLE,
    FSM_CHECK,
    FSM_SCAN,
    FSM_DONE
  } fsm_e;

  // Final verdict of a completed scan
  function automatic res_status_e scan_outcome(input logic any_hit, input logic multi_hit);
    if (multi_hit) return ST_DUP;
    if (any_hit)   return ST_FOUND;
    return ST_NODISP;
  endfunction

  // Format 0 with ignored target bits asks for a logical-server search
  function automatic logic is_ls_request(input logic fmt, input logic ign);
    return !fmt && ign;
  endfunction

endpackage

// File: rtl/disp_vld_table.sv
module disp_vld_table #(
  parameter int DEPTH = 16,
  parameter int ID_W  = 6,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic            wdata,
  input  logic [ID_W-1:0] rd_id,
  output logic            rd_ok
);

  logic [DEPTH-1:0] bits_q;
  logic             in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      bits_q[waddr] <= wdata;
    end
  end

  // An id beyond the table is a failed lookup
  assign in_range = int'(rd_id) < DEPTH;
  assign rd_ok    = in_range && bits_q[rd_id[AW-1:0]];

endmodule

// File: rtl/disp_ring_match.sv
module disp_ring_match
  import disp_pkg::*;
#(
  parameter int ID_W = 6,
  parameter int LS_W = 4
) (
  input  logic            fmt,
  input  logic [ID_W-1:0] tgt_id,
  input  logic [LS_W-1:0] tgt_ls,
  input  logic            phys_vld,
  input  logic [ID_W-1:0] phys_id,
  input  logic            pool_vld,
  input  logic [ID_W-1:0] pool_id,
  input  logic            os_vld,
  input  logic [ID_W-1:0] os_id,
  input  logic            usr_vld,
  input  logic [LS_W-1:0] usr_ls,
  output logic            hit,
  output logic [1:0]      ring
);

  logic phys_m, pool_m, os_m, usr_m;

  assign phys_m = phys_vld && (phys_id == tgt_id);
  assign pool_m = pool_vld && (pool_id == tgt_id);
  assign os_m   = os_vld   && (os_id   == tgt_id);
  assign usr_m  = os_m && usr_vld && (usr_ls == tgt_ls);

  always_comb begin
    hit  = 1'b0;
    ring = RING_USER;
    if (fmt) begin
      hit  = usr_m;
      ring = RING_USER;
    end else if (phys_m) begin
      hit  = 1'b1;
      ring = RING_PHYS;
    end else if (pool_m) begin
      hit  = 1'b1;
      ring = RING_POOL;
    end else if (os_m) begin
      hit  = 1'b1;
      ring = RING_OS;
    end
  end

endmodule

// File: rtl/disp_presenter_scan.sv
module disp_presenter_scan
  import disp_pkg::*;
#(
  parameter int NUM_THR   = 4,
  parameter int BLK_W     = 2,
  parameter int IDX_W     = 4,
  parameter int LS_W      = 4,
  parameter int PRIO_W    = 3,
  parameter int TBL_DEPTH = 16,
  localparam int ID_W     = BLK_W + IDX_W,
  localparam int THR_W    = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int TBL_AW   = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_fmt,
  input  logic [BLK_W-1:0]              req_blk,
  input  logic [IDX_W-1:0]              req_idx,
  input  logic                          req_ign,
  input  logic [PRIO_W-1:0]             req_prio,
  input  logic [LS_W-1:0]               req_ls,
  input  logic                          tbl_we,
  input  logic [TBL_AW-1:0]             tbl_addr,
  input  logic                          tbl_vld,
  input  logic [NUM_THR-1:0]            thr_en,
  input  logic [NUM_THR-1:0]            ctx_phys_vld,
  input  logic [NUM_THR-1:0][ID_W-1:0]  ctx_phys_id,
  input  logic [NUM_THR-1:0]            ctx_pool_vld,
  input  logic [NUM_THR-1:0][ID_W-1:0]  ctx_pool_id,
  input  logic [NUM_THR-1:0]            ctx_os_vld,
  input  logic [NUM_THR-1:0][ID_W-1:0]  ctx_os_id,
  input  logic [NUM_THR-1:0]            ctx_usr_vld,
  input  logic [NUM_THR-1:0][LS_W-1:0]  ctx_usr_ls,
  output logic                          res_done,
  output logic [1:0]                    res_status,
  output logic [THR_W-1:0]              res_thread,
  output logic [1:0]                    res_ring,
  output logic [PRIO_W-1:0]             res_prio
);

  localparam logic [THR_W-1:0] LAST_THR = THR_W'(NUM_THR - 1);

  fsm_e              state_q;
  logic              r_fmt, r_ign;
  logic [ID_W-1:0]   r_id;
  logic [PRIO_W-1:0] r_prio;
  logic [LS_W-1:0]   r_ls;
  logic [THR_W-1:0]  ptr;
  logic              hit_seen, dup_seen;
  logic [THR_W-1:0]  first_thr;
  logic [1:0]        first_ring;
  res_status_e       status_q;

  // Named internal events, observed by the bound checker
  logic              acc_fire;
  logic              scan_step;
  logic              scan_hit;
  logic              scan_last;
  logic              reject_now;
  logic              tbl_ok;
  logic              m_hit;
  logic [1:0]        m_ring;

  assign req_ready  = (state_q == FSM_IDLE);
  assign acc_fire   = req_valid && req_ready;
  assign scan_step  = (state_q == FSM_SCAN);
  assign scan_hit   = scan_step && thr_en[ptr] && m_hit;
  assign scan_last  = (ptr == LAST_THR);
  assign reject_now = (state_q == FSM_CHECK) && (!tbl_ok || is_ls_request(r_fmt, r_ign));

  disp_vld_table #(
    .DEPTH (TBL_DEPTH),
    .ID_W  (ID_W)
  ) tbl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_vld),
    .rd_id (r_id),
    .rd_ok (tbl_ok)
  );

  // One shared matcher, fed with the context of the thread under the pointer
  disp_ring_match #(
    .ID_W (ID_W),
    .LS_W (LS_W)
  ) match_i (
    .fmt      (r_fmt),
    .tgt_id   (r_id),
    .tgt_ls   (r_ls),
    .phys_vld (ctx_phys_vld[ptr]),
    .phys_id  (ctx_phys_id[ptr]),
    .pool_vld (ctx_pool_vld[ptr]),
    .pool_id  (ctx_pool_id[ptr]),
    .os_vld   (ctx_os_vld[ptr]),
    .os_id    (ctx_os_id[ptr]),
    .usr_vld  (ctx_usr_vld[ptr]),
    .usr_ls   (ctx_usr_ls[ptr]),
    .hit      (m_hit),
    .ring     (m_ring)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FSM_IDLE;
      r_fmt      <= 1'b0;
      r_ign      <= 1'b0;
      r_id       <= '0;
      r_prio     <= '0;
      r_ls       <= '0;
      ptr        <= '0;
      hit_seen   <= 1'b0;
      dup_seen   <= 1'b0;
      first_thr  <= '0;
      first_ring <= 2'd0;
      status_q   <= ST_INVALID;
    end else begin
      unique case (state_q)
        FSM_IDLE: begin
          if (acc_fire) begin
            r_fmt   <= req_fmt;
            r_ign   <= req_ign;
            r_id    <= {req_blk, req_idx};
            r_prio  <= req_prio;
            r_ls    <= req_ls;
            state_q <= FSM_CHECK;
          end
        end
        FSM_CHECK: begin
          ptr        <= '0;
          hit_seen   <= 1'b0;
          dup_seen   <= 1'b0;
          first_thr  <= '0;
          first_ring <= 2'd0;
          if (reject_now) begin
            status_q <= ST_INVALID;
            state_q  <= FSM_DONE;
          end else begin
            state_q  <= FSM_SCAN;
          end
        end
        FSM_SCAN: begin
          if (scan_hit) begin
            if (hit_seen) begin
              dup_seen <= 1'b1;
            end else begin
              first_thr  <= ptr;
              first_ring <= m_ring;
            end
            hit_seen <= 1'b1;
          end
          if (scan_last) begin
            status_q <= scan_outcome(hit_seen || scan_hit, dup_seen || (hit_seen && scan_hit));
            state_q  <= FSM_DONE;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        FSM_DONE: begin
          state_q <= FSM_IDLE;
        end
        default: state_q <= FSM_IDLE;
      endcase
    end
  end

  assign res_done   = (state_q == FSM_DONE);
  assign res_status = status_q;
  assign res_thread = (status_q == ST_FOUND) ? first_thr  : '0;
  assign res_ring   = (status_q == ST_FOUND) ? first_ring : 2'd0;
  assign res_prio   = r_prio;

endmodule

// File: rtl/disp_scan_chk.sv
module disp_scan_chk #(
  parameter int NUM_THR = 4,
  parameter int THR_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             req_fmt,
  input logic             req_ign,
  input logic             acc_fire,
  input logic             scan_step,
  input logic [THR_W-1:0] ptr,
  input logic             res_done,
  input logic [1:0]       res_status,
  input logic [THR_W-1:0] res_thread,
  input logic [1:0]       res_ring
);

  localparam logic [THR_W-1:0] LAST_THR = THR_W'(NUM_THR - 1);

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> !req_ready);

  // R1
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> req_ready);

  // R1
  busy_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> !req_ready);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  // R3
  ls_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !req_fmt && req_ign) |=> ##1 (res_done && res_status == 2'd3));

  // R11
  zero_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_status != 2'd0) |-> (res_thread == '0 && res_ring == 2'd0));

  // R9
  scan_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_step && ptr != LAST_THR) |=> (scan_step && ptr == THR_W'($past(ptr) + 1'b1)));

endmodule

bind disp_presenter_scan disp_scan_chk #(
  .NUM_THR (NUM_THR),
  .THR_W   (THR_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .req_fmt    (req_fmt),
  .req_ign    (req_ign),
  .acc_fire   (acc_fire),
  .scan_step  (scan_step),
  .ptr        (ptr),
  .res_done   (res_done),
  .res_status (res_status),
  .res_thread (res_thread),
  .res_ring   (res_ring)
);

// File: tb/disp_presenter_scan_tb_top.sv
`timescale 1ns/1ps
module disp_presenter_scan_tb_top;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_fmt = 1'b0;
  logic [1:0]      req_blk = '0;
  logic [3:0]      req_idx = '0;
  logic            req_ign = 1'b0;
  logic [2:0]      req_prio = '0;
  logic [3:0]      req_ls = '0;
  logic            tbl_we = 1'b0;
  logic [3:0]      tbl_addr = '0;
  logic            tbl_vld = 1'b0;
  logic [N-1:0]    thr_en = '0;
  logic [N-1:0]    phys_vld = '0, pool_vld = '0, os_vld = '0, usr_vld = '0;
  logic [N-1:0][5:0] phys_id = '0, pool_id = '0, os_id = '0;
  logic [N-1:0][3:0] usr_ls = '0;
  logic            res_done;
  logic [1:0]      res_status;
  logic [1:0]      res_thread;
  logic [1:0]      res_ring;
  logic [2:0]      res_prio;

  int n_chk = 0;
  int n_err = 0;

  disp_presenter_scan dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_fmt(req_fmt),
    .req_blk(req_blk), .req_idx(req_idx), .req_ign(req_ign),
    .req_prio(req_prio), .req_ls(req_ls),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_vld(tbl_vld),
    .thr_en(thr_en),
    .ctx_phys_vld(phys_vld), .ctx_phys_id(phys_id),
    .ctx_pool_vld(pool_vld), .ctx_pool_id(pool_id),
    .ctx_os_vld(os_vld), .ctx_os_id(os_id),
    .ctx_usr_vld(usr_vld), .ctx_usr_ls(usr_ls),
    .res_done(res_done), .res_status(res_status), .res_thread(res_thread),
    .res_ring(res_ring), .res_prio(res_prio)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int ring_kind(input int mask, input int t, input int fmt);
    return (mask + t + fmt) % 4;
  endfunction

  // Ring expected for a format-0 match of a given kind (R5 priority)
  function automatic int ring_of(input int k);
    if (k == 1) return 2;
    if (k == 2) return 1;
    return 3;
  endfunction

  task automatic set_ctx(input bit fmt, input logic [5:0] tgt, input int mask, input logic [3:0] ls);
    for (int t = 0; t < N; t++) begin
      int k;
      k = ring_kind(mask, t, fmt);
      phys_vld[t] = 1'b0; phys_id[t] = tgt ^ 6'd1;
      pool_vld[t] = 1'b0; pool_id[t] = tgt ^ 6'd2;
      os_vld[t]   = 1'b0; os_id[t]   = tgt ^ 6'd3;
      usr_vld[t]  = 1'b0; usr_ls[t]  = ls;
      if (!fmt) begin
        if (mask[t]) begin
          if (k == 0 || k == 3) begin phys_vld[t] = 1'b1; phys_id[t] = tgt; end
          if (k == 1 || k == 3) begin pool_vld[t] = 1'b1; pool_id[t] = tgt; end
          if (k == 2 || k == 3) begin os_vld[t]   = 1'b1; os_id[t]   = tgt; end
        end else begin
          phys_vld[t] = 1'b1;
          pool_id[t]  = tgt;
          os_vld[t]   = 1'b1;
          usr_vld[t]  = 1'b1;
        end
      end else begin
        phys_vld[t] = 1'b1; phys_id[t] = tgt;
        pool_vld[t] = 1'b1; pool_id[t] = tgt;
        os_id[t]    = tgt;
        if (mask[t]) begin
          os_vld[t] = 1'b1; usr_vld[t] = 1'b1;
        end else begin
          case (t % 3)
            0: begin os_vld[t] = 1'b1; usr_vld[t] = 1'b0; end
            1: begin os_vld[t] = 1'b1; usr_vld[t] = 1'b1; usr_ls[t] = ls ^ 4'd1; end
            default: begin os_vld[t] = 1'b0; usr_vld[t] = 1'b1; end
          endcase
        end
      end
    end
  endtask

  task automatic tbl_write(input int addr, input bit v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'(addr); tbl_vld = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run_req(input bit fmt, input logic [5:0] id, input bit ign,
                         input logic [2:0] prio, input logic [3:0] ls,
                         input int e_st, input int e_thr, input int e_ring, input string tag);
    int lat;
    int e_lat;
    e_lat = (e_st == 3) ? 1 : N + 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready while idle", int'(req_ready), 1);
    req_valid = 1'b1; req_fmt = fmt; req_blk = id[5:4]; req_idx = id[3:0];
    req_ign = ign; req_prio = prio; req_ls = ls;
    @(posedge clk);
    @(negedge clk);
    // R13: scramble request inputs while busy
    req_valid = 1'b0; req_fmt = ~fmt; req_blk = ~id[5:4]; req_idx = ~id[3:0];
    req_ign = ~ign; req_prio = ~prio; req_ls = ~ls;
    chk(req_ready == 1'b0, "R1 ready low after accept", int'(req_ready), 0);
    lat = 0;
    while (!res_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == e_lat, {tag, " R2 latency"}, lat, e_lat);
    chk(res_status == 2'(e_st), {tag, " status"}, int'(res_status), e_st);
    chk(res_thread == 2'(e_thr), {tag, " R11 thread"}, int'(res_thread), e_thr);
    chk(res_ring == 2'(e_ring), {tag, " R11 ring"}, int'(res_ring), e_ring);
    chk(res_prio == prio, "R11 R13 priority echo", int'(res_prio), int'(prio));
    chk(req_ready == 1'b0, "R1 ready low at done", int'(req_ready), 0);
    @(negedge clk);
    chk(res_done == 1'b0, "R11 done one cycle", int'(res_done), 0);
    chk(req_ready == 1'b1, "R1 ready back after done", int'(req_ready), 1);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(req_ready == 1'b1, "R12 ready in reset", int'(req_ready), 1);
    chk(res_done == 1'b0, "R12 done in reset", int'(res_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12 ready after reset", int'(req_ready), 1);

    // R12: table is clear after reset, so a target that would match is invalid
    thr_en = '1;
    set_ctx(1'b0, 6'd5, 15, 4'd0);
    run_req(1'b0, 6'd5, 1'b0, 3'd2, 4'd0, 3, 0, 0, "R12 cleared table");

    // R4: fill the table, entry valid when id mod 3 is non-zero
    for (int a = 0; a < 16; a++) tbl_write(a, (a % 3) != 0);

    // R2 R7 R10: sweep every target id with all threads disabled
    thr_en = '0;
    for (int id = 0; id < 64; id++) begin
      bit ok;
      ok = (id < 16) && ((id % 3) != 0);
      set_ctx(1'b0, 6'(id), 15, 4'd0);
      run_req(1'b0, 6'(id), 1'b0, 3'(id), 4'd0, ok ? 2 : 3, 0, 0,
              ok ? "R7 R10 disabled threads" : "R2 failed lookup");
    end

    // R4: clearing an entry turns a dispatchable target invalid
    tbl_write(7, 1'b0);
    thr_en = '1;
    set_ctx(1'b0, 6'd7, 1, 4'd0);
    run_req(1'b0, 6'd7, 1'b0, 3'd1, 4'd0, 3, 0, 0, "R4 entry cleared");
    tbl_write(7, 1'b1);

    // R5 R6 R7 R8 R9 R10: every match pattern against every enable mask, both formats
    for (int f = 0; f < 2; f++) begin
      for (int mask = 0; mask < 16; mask++) begin
        for (int en = 0; en < 16; en++) begin
          int hits, cnt, first, e_st, e_ring;
          string tag;
          hits = mask & en;
          cnt = $countones(4'(hits));
          first = 0;
          for (int t = N - 1; t >= 0; t--) if (hits[t]) first = t;
          if (cnt == 0) begin e_st = 2; tag = "R10 none"; end
          else if (cnt == 1) begin e_st = 0; tag = (f == 1) ? "R6 R8 single" : "R5 R8 single"; end
          else begin e_st = 1; tag = "R9 duplicate"; end
          if (en != 15) tag = {tag, " R7"};
          e_ring = (e_st != 0) ? 0 : ((f == 1) ? 0 : ring_of(ring_kind(mask, first, f)));
          thr_en = 4'(en);
          set_ctx(f[0], 6'd7, mask, 4'(en));
          run_req(f[0], 6'd7, 1'b0, 3'(mask), 4'(en), e_st, (e_st == 0) ? first : 0, e_ring, tag);
        end
      end
    end

    // R3: logical-server request rejected even when threads match
    thr_en = '1;
    set_ctx(1'b0, 6'd7, 15, 4'd3);
    run_req(1'b0, 6'd7, 1'b1, 3'd6, 4'd3, 3, 0, 0, "R3 logical server");
    // R3: ignore flag has no effect in format 1
    set_ctx(1'b1, 6'd7, 4, 4'd9);
    run_req(1'b1, 6'd7, 1'b1, 3'd5, 4'd9, 0, 2, 0, "R3 format 1 ignore");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule